// File: doc/BRIEF.md
# Width-Limited In-Order Retirement Sequencer

This block decides, every cycle, which of the oldest entries of one thread's reorder buffer may leave it. The buffer presents a window of its first `W` entries, each with a handful of status flags. The block walks that window from the oldest entry. It retires ordinary completed entries and drops squashed ones. It stops at the first entry it cannot handle in the current cycle. Up to `W` entries retire per cycle, and the retire mask is always a contiguous run starting at the oldest slot.

Entries that need special handling are allowed to act only when they would be the first real commit of the cycle and no store is still waiting to be written back. These are unexecuted serialising instructions (barriers or non-speculative operations), unexecuted loads that must be replayed uncached, and faulting entries. A serialising instruction or load sends its sequence number back to the execution side as a request. A fault starts a trap timer, and when the timer runs out the block emits a one-cycle squash for the thread. The per-cycle commit count, a bandwidth-saturation flag and a store-retired flag are registered. A buffer-drained indication is suppressed while stores are pending or just after a store retires.

Top module: `commit_ctrl`

## Requirements
- R1: Window slot i uses bit i of each flag vector, and slot 0 is the oldest. Scanning starts at slot 0. A slot that is valid, ready, not squashed, executed and not faulting is retired (its `retire_o` bit is high). Scanning stops at the first slot that is invalid or not ready, so `retire_o` is always a contiguous run from bit 0.
- R2: A valid, ready, squashed slot is retired whatever its other flags are, does not count as a commit, and scanning continues past it.
- R3: `cnt_o` holds, one cycle later, the number of retired slots that were not squashed.
- R4: An unexecuted slot with `hd_nonspec_i` set stops the scan without retiring. If no non-squashed slot retired before it in that cycle and `stores_pending_i` is low, `ns_req_o` goes high with `ns_uncached_o` low, and `ns_seq_o` equals that slot's sequence field (bits `[i*SEQ_W +: SEQ_W]` of `hd_seq_i`). Otherwise no request is made.
- R5: An unexecuted slot with `hd_load_i` set and `hd_nonspec_i` clear follows the same rule as R4, but its request has `ns_uncached_o` high.
- R6: An executed, faulting slot stops the scan without retiring. Under the same gating as R4, `trap_pending_o` rises at the next edge. If the gating fails, nothing changes.
- R7: `trap_pending_o` stays high for exactly `TRAP_LAT` cycles. It is then followed by exactly one cycle of `trap_squash_o` with `trap_pending_o` low.
- R8: While `trap_pending_o` or `trap_squash_o` is high, nothing retires, no request is made, and no new trap starts.
- R9: `bw_limit_o` is high one cycle after a cycle whose commit count equalled `W`, and low otherwise.
- R10: `empty_ok_o` equals `rob_empty_i` and not `stores_pending_i`, and is additionally forced low in the cycle after a cycle in which a store retired.
- R11: An unexecuted slot with neither `hd_nonspec_i` nor `hd_load_i` stops the scan without retiring and without any request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hd_valid_i | input | W | Slot holds an entry |
| hd_ready_i | input | W | Entry marked ready to leave |
| hd_squashed_i | input | W | Entry was squashed |
| hd_executed_i | input | W | Entry has executed |
| hd_nonspec_i | input | W | Serialising / barrier entry |
| hd_load_i | input | W | Entry is a load |
| hd_store_i | input | W | Entry is a store |
| hd_fault_i | input | W | Entry carries a fault |
| hd_seq_i | input | W*SEQ_W | Sequence number per slot |
| stores_pending_i | input | 1 | Stores still awaiting writeback |
| rob_empty_i | input | 1 | Buffer currently empty |
| retire_o | output | W | Slots leaving the buffer this cycle |
| cnt_o | output | CW | Registered commit count of last cycle |
| bw_limit_o | output | 1 | Last cycle committed the full width |
| ns_req_o | output | 1 | Request to execute the head non-speculatively |
| ns_uncached_o | output | 1 | Request is an uncached load replay |
| ns_seq_o | output | SEQ_W | Sequence number of the request |
| trap_pending_o | output | 1 | Trap timer running |
| trap_squash_o | output | 1 | One-cycle squash at trap expiry |
| empty_ok_o | output | 1 | Buffer drained and safe to report empty |

## Verification
`retire_o`, `ns_req_o`, `ns_uncached_o`, `ns_seq_o` and `empty_ok_o` respond combinationally in the same cycle as the inputs. The bench samples them 1.5 ns after driving on the falling edge. `cnt_o`, `bw_limit_o` and the rise of `trap_pending_o` follow one rising edge later and are checked at the next falling edge against expectations held over from the previous cycle. The squash pulse appears `TRAP_LAT` edges after the pending rise, and the bench model counts those edges itself and checks pending and squash every cycle.

// File: rtl/commit_pkg.sv
package commit_pkg;
  typedef enum logic [1:0] {
    TRP_RUN  = 2'd0,
    TRP_WAIT = 2'd1,
    TRP_SQSH = 2'd2
  } trap_st_e;
endpackage

// File: rtl/commit_scan.sv
module commit_scan #(
  parameter int W     = 4,
  parameter int SEQ_W = 8,
  localparam int CW   = $clog2(W + 1)
) (
  input  logic             enable,
  input  logic [W-1:0]     hd_valid,
  input  logic [W-1:0]     hd_ready,
  input  logic [W-1:0]     hd_squashed,
  input  logic [W-1:0]     hd_executed,
  input  logic [W-1:0]     hd_nonspec,
  input  logic [W-1:0]     hd_load,
  input  logic [W-1:0]     hd_store,
  input  logic [W-1:0]     hd_fault,
  input  logic [W*SEQ_W-1:0] hd_seq,
  input  logic             stores_pending,
  output logic [W-1:0]     retire,
  output logic [CW-1:0]    n_commit,
  output logic             store_ret,
  output logic             ns_req,
  output logic             ns_uncached,
  output logic [SEQ_W-1:0] ns_seq,
  output logic             fault_take
);
  logic          go;
  logic [CW-1:0] cnt;

  always_comb begin
    go          = enable;
    cnt         = '0;
    retire      = '0;
    store_ret   = 1'b0;
    ns_req      = 1'b0;
    ns_uncached = 1'b0;
    ns_seq      = '0;
    fault_take  = 1'b0;
    for (int i = 0; i < W; i++) begin
      if (go) begin
        if (!hd_valid[i] || !hd_ready[i]) begin
          go = 1'b0;
        end else if (hd_squashed[i]) begin
          retire[i] = 1'b1;
        end else if (!hd_executed[i]) begin
          go = 1'b0;
          if ((hd_nonspec[i] || hd_load[i]) && cnt == '0 && !stores_pending) begin
            ns_req      = 1'b1;
            ns_uncached = hd_load[i] && !hd_nonspec[i];
            ns_seq      = hd_seq[i*SEQ_W +: SEQ_W];
          end
        end else if (hd_fault[i]) begin
          go = 1'b0;
          if (cnt == '0 && !stores_pending) fault_take = 1'b1;
        end else begin
          retire[i] = 1'b1;
          cnt       = cnt + CW'(1);
          if (hd_store[i]) store_ret = 1'b1;
        end
      end
    end
    n_commit = cnt;
  end
endmodule

// File: rtl/commit_trap_timer.sv
module commit_trap_timer
  import commit_pkg::*;
#(
  parameter int TRAP_LAT = 3,
  localparam int TW      = (TRAP_LAT > 1) ? $clog2(TRAP_LAT) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fault_take,
  output logic pending,
  output logic squash
);
  trap_st_e      st_q, st_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          tmr_en;

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    tmr_en = 1'b0;
    case (st_q)
      TRP_RUN: begin
        if (fault_take) begin
          st_d   = TRP_WAIT;
          tmr_d  = TW'(TRAP_LAT - 1);
          tmr_en = 1'b1;
        end
      end
      TRP_WAIT: begin
        if (tmr_q == '0) begin
          st_d = TRP_SQSH;
        end else begin
          tmr_d  = tmr_q - TW'(1);
          tmr_en = 1'b1;
        end
      end
      default: st_d = TRP_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= TRP_RUN;
      tmr_q <= '0;
    end else begin
      st_q <= st_d;
      if (tmr_en) tmr_q <= tmr_d;
    end
  end

  assign pending = (st_q == TRP_WAIT);
  assign squash  = (st_q == TRP_SQSH);
endmodule

// File: rtl/commit_stat_regs.sv
module commit_stat_regs #(
  parameter int W    = 4,
  localparam int CW  = $clog2(W + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] n_commit,
  input  logic          store_ret,
  output logic [CW-1:0] cnt_q,
  output logic          bw_q,
  output logic          st_q
);
  logic [CW-1:0] cnt_d;
  logic          bw_d;
  logic          st_d;

  always_comb begin
    cnt_d = n_commit;
    bw_d  = (n_commit == CW'(W));
    st_d  = store_ret;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      bw_q  <= 1'b0;
      st_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      bw_q  <= bw_d;
      st_q  <= st_d;
    end
  end
endmodule

// File: rtl/commit_ctrl.sv
module commit_ctrl #(
  parameter int W        = 4,
  parameter int SEQ_W    = 8,
  parameter int TRAP_LAT = 3,
  localparam int CW      = $clog2(W + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [W-1:0]       hd_valid_i,
  input  logic [W-1:0]       hd_ready_i,
  input  logic [W-1:0]       hd_squashed_i,
  input  logic [W-1:0]       hd_executed_i,
  input  logic [W-1:0]       hd_nonspec_i,
  input  logic [W-1:0]       hd_load_i,
  input  logic [W-1:0]       hd_store_i,
  input  logic [W-1:0]       hd_fault_i,
  input  logic [W*SEQ_W-1:0] hd_seq_i,
  input  logic               stores_pending_i,
  input  logic               rob_empty_i,
  output logic [W-1:0]       retire_o,
  output logic [CW-1:0]      cnt_o,
  output logic               bw_limit_o,
  output logic               ns_req_o,
  output logic               ns_uncached_o,
  output logic [SEQ_W-1:0]   ns_seq_o,
  output logic               trap_pending_o,
  output logic               trap_squash_o,
  output logic               empty_ok_o
);
  logic          scan_en;
  logic [CW-1:0] n_commit;
  logic          store_ret;
  logic          fault_take;
  logic          store_prev;

  assign scan_en = !(trap_pending_o || trap_squash_o);

  commit_scan #(.W(W), .SEQ_W(SEQ_W)) u_scan (
    .enable         (scan_en),
    .hd_valid       (hd_valid_i),
    .hd_ready       (hd_ready_i),
    .hd_squashed    (hd_squashed_i),
    .hd_executed    (hd_executed_i),
    .hd_nonspec     (hd_nonspec_i),
    .hd_load        (hd_load_i),
    .hd_store       (hd_store_i),
    .hd_fault       (hd_fault_i),
    .hd_seq         (hd_seq_i),
    .stores_pending (stores_pending_i),
    .retire         (retire_o),
    .n_commit       (n_commit),
    .store_ret      (store_ret),
    .ns_req         (ns_req_o),
    .ns_uncached    (ns_uncached_o),
    .ns_seq         (ns_seq_o),
    .fault_take     (fault_take)
  );

  commit_trap_timer #(.TRAP_LAT(TRAP_LAT)) u_trap (
    .clk        (clk),
    .rst_n      (rst_n),
    .fault_take (fault_take),
    .pending    (trap_pending_o),
    .squash     (trap_squash_o)
  );

  commit_stat_regs #(.W(W)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .n_commit  (n_commit),
    .store_ret (store_ret),
    .cnt_q     (cnt_o),
    .bw_q      (bw_limit_o),
    .st_q      (store_prev)
  );

  assign empty_ok_o = rob_empty_i && !stores_pending_i && !store_prev;
endmodule

// File: rtl/commit_ctrl_chk.sv
module commit_ctrl_chk #(
  parameter int W    = 4,
  localparam int CW  = $clog2(W + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [W-1:0]  hd_squashed_i,
  input logic          stores_pending_i,
  input logic [W-1:0]  retire_o,
  input logic [CW-1:0] cnt_o,
  input logic          bw_limit_o,
  input logic          ns_req_o,
  input logic          trap_pending_o,
  input logic          trap_squash_o
);
  logic seen_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  p_prefix_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ((retire_o + W'(1)) & retire_o) == '0);

  p_cnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> 32'(cnt_o) == $past($countones(retire_o & ~hd_squashed_i)));

  p_ns_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ns_req_o |-> !stores_pending_i);

  p_fault_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trap_pending_o) |-> $past(!stores_pending_i));

  p_fall_to_squash_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(trap_pending_o) |-> trap_squash_o);

  p_squash_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    trap_squash_o |=> !trap_squash_o && !trap_pending_o);

  p_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_pending_o || trap_squash_o) |-> (retire_o == '0 && !ns_req_o));

  p_bw_r9: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q |-> bw_limit_o == ($past($countones(retire_o & ~hd_squashed_i)) == W));
endmodule

bind commit_ctrl commit_ctrl_chk #(.W(W)) u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .hd_squashed_i    (hd_squashed_i),
  .stores_pending_i (stores_pending_i),
  .retire_o         (retire_o),
  .cnt_o            (cnt_o),
  .bw_limit_o       (bw_limit_o),
  .ns_req_o         (ns_req_o),
  .trap_pending_o   (trap_pending_o),
  .trap_squash_o    (trap_squash_o)
);

// File: tb/sim_commit_ctrl.sv
`timescale 1ns/100ps
module sim_commit_ctrl;
  localparam int W     = 4;
  localparam int SEQ_W = 8;
  localparam int LAT   = 3;
  localparam int CW    = $clog2(W + 1);

  logic clk, rst_n;
  logic [W-1:0] v, r, sq, ex, ns, ld, st, ft;
  logic [W*SEQ_W-1:0] seqf;
  logic sp, re;
  logic [W-1:0] retire_o;
  logic [CW-1:0] cnt_o;
  logic bw_limit_o, ns_req_o, ns_uncached_o, trap_pending_o, trap_squash_o, empty_ok_o;
  logic [SEQ_W-1:0] ns_seq_o;

  int tests = 0, fails = 0;
  int exp_cnt = 0; bit exp_bw = 0; bit prev_st = 0;
  int tstate = 0; int trem = 0;

  commit_ctrl #(.W(W), .SEQ_W(SEQ_W), .TRAP_LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .hd_valid_i(v), .hd_ready_i(r), .hd_squashed_i(sq),
    .hd_executed_i(ex), .hd_nonspec_i(ns), .hd_load_i(ld), .hd_store_i(st),
    .hd_fault_i(ft), .hd_seq_i(seqf), .stores_pending_i(sp), .rob_empty_i(re),
    .retire_o(retire_o), .cnt_o(cnt_o), .bw_limit_o(bw_limit_o), .ns_req_o(ns_req_o),
    .ns_uncached_o(ns_uncached_o), .ns_seq_o(ns_seq_o), .trap_pending_o(trap_pending_o),
    .trap_squash_o(trap_squash_o), .empty_ok_o(empty_ok_o));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] expv);
    tests++;
    if (got !== expv) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, expv);
    end
  endtask

  // Reference built from the written requirements.
  task automatic model(input logic [W-1:0] mv, mr, msq, mex, mns, mld, mst, mft,
                       input logic msp, input bit blk,
                       output logic [W-1:0] ret, output int n, output bit req,
                       output bit unc, output int rs, output bit take, output bit stret);
    bit go = !blk;
    ret = '0; n = 0; req = 0; unc = 0; rs = 0; take = 0; stret = 0;
    for (int i = 0; i < W; i++) begin
      if (go) begin
        if (!mv[i] || !mr[i]) go = 0;
        else if (msq[i]) ret[i] = 1'b1;
        else if (!mex[i]) begin
          go = 0;
          if ((mns[i] || mld[i]) && n == 0 && !msp) begin
            req = 1; unc = mld[i] && !mns[i]; rs = i;
          end
        end else if (mft[i]) begin
          go = 0;
          if (n == 0 && !msp) take = 1;
        end else begin
          ret[i] = 1'b1; n++;
          if (mst[i]) stret = 1;
        end
      end
    end
  endtask

  task automatic cycle(input logic [W-1:0] a_v, a_r, a_sq, a_ex, a_ns, a_ld, a_st, a_ft,
                       input logic [W*SEQ_W-1:0] a_seq, input logic a_sp, a_re);
    logic [W-1:0] eret; int en, ers; bit ereq, eunc, etake, estr;
    @(negedge clk);
    chk("R3 count", 32'(cnt_o), 32'(exp_cnt));
    chk("R9 bw_limit", 32'(bw_limit_o), 32'(exp_bw));
    chk("R6/R7 trap_pending", 32'(trap_pending_o), 32'(tstate == 1));
    chk("R7 trap_squash", 32'(trap_squash_o), 32'(tstate == 2));
    v = a_v; r = a_r; sq = a_sq; ex = a_ex; ns = a_ns; ld = a_ld; st = a_st; ft = a_ft;
    seqf = a_seq; sp = a_sp; re = a_re;
    #1.5;
    model(a_v, a_r, a_sq, a_ex, a_ns, a_ld, a_st, a_ft, a_sp, tstate != 0,
          eret, en, ereq, eunc, ers, etake, estr);
    chk("R1/R2/R8 retire", 32'(retire_o), 32'(eret));
    chk("R4/R11 ns_req", 32'(ns_req_o), 32'(ereq));
    if (ereq) begin
      chk("R5 ns_uncached", 32'(ns_uncached_o), 32'(eunc));
      chk("R4 ns_seq", 32'(ns_seq_o), 32'(a_seq[ers*SEQ_W +: SEQ_W]));
    end
    chk("R10 empty_ok", 32'(empty_ok_o), 32'(a_re && !a_sp && !prev_st));
    exp_cnt = en; exp_bw = (en == W); prev_st = estr;
    if (tstate == 1) begin
      trem--;
      if (trem == 0) tstate = 2;
    end else if (tstate == 2) tstate = 0;
    else if (etake) begin tstate = 1; trem = LAT; end
  endtask

  initial begin
    #(200000 * 5);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [W-1:0] a, b, c, d, e, f, g, h;
    int nv;
    void'($urandom(32'd4711));
    v = '0; r = '0; sq = '0; ex = '0; ns = '0; ld = '0; st = '0; ft = '0;
    seqf = '0; sp = 1'b0; re = 1'b1;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R3 reset count", 32'(cnt_o), 0);
    chk("R9 reset bw", 32'(bw_limit_o), 0);
    chk("R7 reset pending", 32'(trap_pending_o), 0);
    chk("R7 reset squash", 32'(trap_squash_o), 0);
    chk("R10 reset empty_ok", 32'(empty_ok_o), 1);
    rst_n = 1'b1;
    // R1/R9: full width of plain commits, one of them a store (R10 next cycle)
    cycle('1, '1, '0, '1, '0, '0, 4'b0100, '0, 32'h44332211, 0, 0);
    cycle('0, '0, '0, '0, '0, '0, '0, '0, '0, 0, 1);
    cycle('0, '0, '0, '0, '0, '0, '0, '0, '0, 0, 1);
    // R2/R4: squashed slot 0 then unexecuted barrier in slot 1
    cycle('1, '1, 4'b0001, 4'b1101, 4'b0010, '0, '0, '0, 32'hA4A3A2A1, 0, 0);
    // R5: uncached load after a commit is refused, alone is accepted
    cycle('1, '1, '0, 4'b1101, '0, 4'b0010, '0, '0, 32'h0B0A0908, 0, 0);
    cycle('1, '1, '0, 4'b1110, '0, 4'b0001, '0, '0, 32'h0B0A0977, 0, 0);
    // R4: pending stores block the request
    cycle('1, '1, '0, 4'b1110, 4'b0001, '0, '0, '0, 32'h01020304, 1, 0);
    // R11: unexecuted plain head
    cycle('1, '1, '0, 4'b1110, '0, '0, '0, '0, 32'h0, 0, 0);
    // R1: not-ready slot 2 stops the scan
    cycle('1, 4'b1011, '0, '1, '0, '0, '0, '0, 32'h0, 0, 0);
    // R6: fault refused under pending stores, then taken; R8 blocking during the timer
    cycle('1, '1, '0, '1, '0, '0, '0, 4'b0001, 32'h0, 1, 0);
    cycle('1, '1, '0, '1, '0, '0, '0, 4'b0001, 32'h0, 0, 0);
    for (int k = 0; k < LAT + 2; k++)
      cycle('1, '1, '0, '1, '0, '0, '0, '0, 32'h0, 0, 0);
    // Random mix
    for (int k = 0; k < 3000; k++) begin
      nv = $urandom_range(0, W);
      a = '0; b = '0; c = '0; d = '0; e = '0; f = '0; g = '0; h = '0;
      for (int i = 0; i < W; i++) begin
        a[i] = (i < nv);
        b[i] = ($urandom_range(0, 9) != 0);
        c[i] = ($urandom_range(0, 6) == 0);
        d[i] = ($urandom_range(0, 6) != 0);
        e[i] = ($urandom_range(0, 9) == 0);
        f[i] = ($urandom_range(0, 6) == 0);
        g[i] = ($urandom_range(0, 3) == 0);
        h[i] = ($urandom_range(0, 29) == 0);
      end
      cycle(a, b, c, d, e, f, g, h, W*SEQ_W'($urandom()),
            ($urandom_range(0, 3) == 0), (nv == 0) ? 1'b1 : 1'b0);
    end
    @(negedge clk);
    chk("R3 final count", 32'(cnt_o), 32'(exp_cnt));
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule